// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical timing of a display raster from a pixel-rate enable. Both position counters restart at zero on the leading edge of sync. Each line, and each frame, therefore runs in this order: sync, back porch, visible region, front porch. Every boundary is programmed as an index counted from that origin.

Configuration arrives as 32-bit words. Each word carries the vertical quantity in bits 31:16 and the horizontal quantity in bits 15:0. Words go into a pending set and are copied to the working set only at the frame origin, so a frame never mixes two timings.

Interlaced scanning uses a single vertical count that spans both fields and is odd in length. A second vertical window locates the visible lines of the later field. The field indicator marks the later field, and a second vertical sync pulse starts with it.

Top module: `raster_timing_gen`

## Requirements
- R1: A configuration word holds the vertical value in bits 31:16 and the horizontal value in bits 15:0. `cfg_sel` picks the word: 0 line/frame length, 1 sync last index, 2 back-porch last index, 3 last visible index, 4 later-field window (bits 31:16 its last blank line, bits 15:0 its last visible line), 5 mode (bit 0 set selects interlace).
- R2: The pixel counter advances only in cycles with `pix_en` high and returns to 0 after reaching length minus one. The line counter advances only when the pixel counter returns to 0.
- R3: `hsync` is high while the pixel index is at most the horizontal sync value. `vsync` is high while the line index, measured from the start of the current field, is at most the vertical sync value.
- R4: An index is visible when it is above the back-porch value and at most the last-visible value. `de` is high only when both the pixel and the line are visible.
- R5: With mode bit 0 clear, the line length counts whole frames, `field` stays low, and the later-field window has no effect.
- R6: With mode bit 0 set, the later field starts at line F = window-blank value minus vertical back-porch value. From line F onward `field` is high, `vsync` is high for lines F through F plus the sync value, and the visible lines are those above the window-blank value and at most the window-visible value.
- R7: A configuration write changes nothing in the frame under way. It takes effect from the next frame origin (pixel 0, line 0).
- R8: During and right after reset, both counters are 0, `hsync` and `vsync` are high, `de` and `field` are low, and the working set holds the parameter defaults.
- R9: A write with `cfg_sel` of 6 or 7 changes no timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-rate advance enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration word select |
| cfg_data | input | 32 | Configuration word |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Visible-pixel enable |
| field | output | 1 | High during the later interlaced field |
| pix_x | output | CNT_W | Current pixel index |
| line_y | output | CNT_W | Current line index |

## Verification
The case that is hardest to reach from the ports is a configuration write that lands in the middle of a frame. The frame it lands in must finish with the old length, and only the following frame may use the new one. The bench counts pixels from one origin to the next. Part way through that count it rewrites the line length, then checks that the current frame keeps its old pixel total and the next frame shows the new total. The enable is gapped throughout, so every count also confirms that idle cycles are not counted as pixels. The interlaced case compares the number of pixels with `field` high, with `vsync` high and with `de` high against totals worked out by hand from F and the odd line count.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   localparam int HALF_W = 16;
   localparam int WORD_W = 2 * HALF_W;

   typedef enum logic [2:0] {
      SEL_LENGTH   = 3'd0,
      SEL_SYNC     = 3'd1,
      SEL_PORCH    = 3'd2,
      SEL_LASTVIS  = 3'd3,
      SEL_FIELD2   = 3'd4,
      SEL_MODE     = 3'd5
   } cfg_sel_e;

   typedef struct packed {
      logic [HALF_W-1:0] length;
      logic [HALF_W-1:0] sync_last;
      logic [HALF_W-1:0] porch_last;
      logic [HALF_W-1:0] vis_last;
   } axis_cfg_t;

   typedef struct packed {
      axis_cfg_t         h;
      axis_cfg_t         v;
      logic [HALF_W-1:0] f2_blank;
      logic [HALF_W-1:0] f2_vis;
      logic              ilace;
   } timing_cfg_t;

   function automatic logic [HALF_W-1:0] vert_of(input logic [WORD_W-1:0] w);
      return w[WORD_W-1:HALF_W];
   endfunction

   function automatic logic [HALF_W-1:0] horz_of(input logic [WORD_W-1:0] w);
      return w[HALF_W-1:0];
   endfunction
endpackage

// File: rtl/rtg_shadow.sv
module rtg_shadow
   import rtg_pkg::*;
#(
   parameter logic [31:0] DEF_LENGTH  = 32'h000C_0014,
   parameter logic [31:0] DEF_SYNC    = 32'h0001_0002,
   parameter logic [31:0] DEF_PORCH   = 32'h0003_0006,
   parameter logic [31:0] DEF_LASTVIS = 32'h000A_0011,
   parameter logic [31:0] DEF_FIELD2  = 32'h0000_0001,
   parameter bit          DEF_ILACE   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              load,
   output timing_cfg_t       act
);
   localparam timing_cfg_t DEF_CFG = '{
      h: '{length: horz_of(DEF_LENGTH), sync_last: horz_of(DEF_SYNC),
           porch_last: horz_of(DEF_PORCH), vis_last: horz_of(DEF_LASTVIS)},
      v: '{length: vert_of(DEF_LENGTH), sync_last: vert_of(DEF_SYNC),
           porch_last: vert_of(DEF_PORCH), vis_last: vert_of(DEF_LASTVIS)},
      f2_blank: vert_of(DEF_FIELD2),
      f2_vis:   horz_of(DEF_FIELD2),
      ilace:    DEF_ILACE
   };

   timing_cfg_t pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= DEF_CFG;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_LENGTH: begin
               pend.h.length <= horz_of(wr_data);
               pend.v.length <= vert_of(wr_data);
            end
            SEL_SYNC: begin
               pend.h.sync_last <= horz_of(wr_data);
               pend.v.sync_last <= vert_of(wr_data);
            end
            SEL_PORCH: begin
               pend.h.porch_last <= horz_of(wr_data);
               pend.v.porch_last <= vert_of(wr_data);
            end
            SEL_LASTVIS: begin
               pend.h.vis_last <= horz_of(wr_data);
               pend.v.vis_last <= vert_of(wr_data);
            end
            SEL_FIELD2: begin
               pend.f2_blank <= vert_of(wr_data);
               pend.f2_vis   <= horz_of(wr_data);
            end
            SEL_MODE: pend.ilace <= wr_data[0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    act <= DEF_CFG;
      else if (load) act <= pend;
   end
endmodule

// File: rtl/rtg_counter.sv
module rtg_counter #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [15:0]      length,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   logic [16:0] cnt_next;

   assign cnt_next = 17'(cnt) + 17'd1;
   assign last     = (cnt_next >= {1'b0, length});

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt <= '0;
      else if (step) cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/rtg_window.sv
module rtg_window (
   input  logic [15:0] sync_pos,
   input  logic [15:0] vis_pos,
   input  logic [15:0] sync_last,
   input  logic [15:0] porch_last,
   input  logic [15:0] vis_last,
   output logic        in_sync,
   output logic        in_vis
);
   assign in_sync = (sync_pos <= sync_last);
   assign in_vis  = (vis_pos > porch_last) && (vis_pos <= vis_last);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int          CNT_W       = 12,
   parameter logic [31:0] DEF_LENGTH  = 32'h000C_0014,
   parameter logic [31:0] DEF_SYNC    = 32'h0001_0002,
   parameter logic [31:0] DEF_PORCH   = 32'h0003_0006,
   parameter logic [31:0] DEF_LASTVIS = 32'h000A_0011,
   parameter logic [31:0] DEF_FIELD2  = 32'h0000_0001,
   parameter bit          DEF_ILACE   = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_sel,
   input  logic [31:0]      cfg_data,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             field,
   output logic [CNT_W-1:0] pix_x,
   output logic [CNT_W-1:0] line_y
);
   localparam int POS_W = HALF_W;

   generate
      if (CNT_W < 2 || CNT_W > POS_W) begin : g_bad_width
         $error("raster_timing_gen: CNT_W must lie in 2..16");
      end
      if (DEF_LENGTH[15:0] == 16'd0 || DEF_LENGTH[31:16] == 16'd0) begin : g_bad_length
         $error("raster_timing_gen: default line and frame length must be nonzero");
      end
   endgenerate

   timing_cfg_t      act;
   logic [CNT_W-1:0] hcnt, vcnt;
   logic             h_last, v_last, frame_wrap;
   logic [POS_W-1:0] h_pos, v_pos, f2_start, v_rel;
   logic [POS_W-1:0] v_porch_sel, v_vis_sel;
   logic             later_field;
   logic             h_sync, h_vis, v_sync, v_vis;

   assign frame_wrap = pix_en & h_last & v_last;

   rtg_shadow #(
      .DEF_LENGTH (DEF_LENGTH),
      .DEF_SYNC   (DEF_SYNC),
      .DEF_PORCH  (DEF_PORCH),
      .DEF_LASTVIS(DEF_LASTVIS),
      .DEF_FIELD2 (DEF_FIELD2),
      .DEF_ILACE  (DEF_ILACE)
   ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_data(cfg_data),
      .load   (frame_wrap),
      .act    (act)
   );

   rtg_counter #(.CNT_W(CNT_W)) u_hcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en),
      .length(act.h.length),
      .cnt   (hcnt),
      .last  (h_last)
   );

   rtg_counter #(.CNT_W(CNT_W)) u_vcnt (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (pix_en & h_last),
      .length(act.v.length),
      .cnt   (vcnt),
      .last  (v_last)
   );

   assign h_pos = POS_W'(hcnt);
   assign v_pos = POS_W'(vcnt);

   // Later field begins one field length after the frame origin.
   assign f2_start    = act.f2_blank - act.v.porch_last;
   assign later_field = act.ilace && (v_pos >= f2_start);
   assign v_rel       = later_field ? (v_pos - f2_start) : v_pos;
   assign v_porch_sel = later_field ? act.f2_blank : act.v.porch_last;
   assign v_vis_sel   = later_field ? act.f2_vis   : act.v.vis_last;

   rtg_window u_hwin (
      .sync_pos  (h_pos),
      .vis_pos   (h_pos),
      .sync_last (act.h.sync_last),
      .porch_last(act.h.porch_last),
      .vis_last  (act.h.vis_last),
      .in_sync   (h_sync),
      .in_vis    (h_vis)
   );

   rtg_window u_vwin (
      .sync_pos  (v_rel),
      .vis_pos   (v_pos),
      .sync_last (act.v.sync_last),
      .porch_last(v_porch_sel),
      .vis_last  (v_vis_sel),
      .in_sync   (v_sync),
      .in_vis    (v_vis)
   );

   assign hsync  = h_sync;
   assign vsync  = v_sync;
   assign de     = h_vis & v_vis;
   assign field  = later_field;
   assign pix_x  = hcnt;
   assign line_y = vcnt;
endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_en,
   input logic             hsync,
   input logic             vsync,
   input logic             de,
   input logic             field,
   input logic             ilace_act,
   input logic [CNT_W-1:0] pix_x,
   input logic [CNT_W-1:0] line_y
);
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ($stable(pix_x) && $stable(line_y))); // R2

   AST_PIXEL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> ((pix_x == $past(pix_x) + 1'b1) || (pix_x == '0))); // R2

   AST_LINE_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> ((pix_x == '0) || $stable(line_y))); // R2

   AST_ORIGIN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      ((pix_x == '0) && (line_y == '0)) |-> (hsync && vsync && !field)); // R3

   AST_DE_OUT_OF_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      de |-> !hsync); // R4

   AST_PROG_NO_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ilace_act |-> !field); // R5
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pix_en   (pix_en),
   .hsync    (hsync),
   .vsync    (vsync),
   .de       (de),
   .field    (field),
   .ilace_act(act.ilace),
   .pix_x    (pix_x),
   .line_y   (line_y)
);

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;
   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pix_en = 1'b0;
   logic             cfg_we = 1'b0;
   logic [2:0]       cfg_sel = 3'd0;
   logic [31:0]      cfg_data = 32'd0;
   logic             hsync, vsync, de, field;
   logic [CNT_W-1:0] pix_x, line_y;

   logic en_allow = 1'b0;
   int   n_checks = 0;
   int   n_errs = 0;

   always #5 clk = ~clk;

   raster_timing_gen #(.CNT_W(CNT_W)) u_raster_timing_gen (
      .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_data(cfg_data), .hsync(hsync), .vsync(vsync),
      .de(de), .field(field), .pix_x(pix_x), .line_y(line_y)
   );

   // gapped enable: two of every three cycles
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         pix_en <= en_allow && (ph != 2);
         ph = (ph == 2) ? 0 : ph + 1;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end

   task automatic step();
      @(negedge clk);
      #2;
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
      cfg_we = 1'b1; cfg_sel = sel; cfg_data = data;
      step();
      cfg_we = 1'b0;
   endtask

   task automatic leave_origin();
      do step(); while (pix_x == '0 && line_y == '0);
   endtask

   // count one frame from origin to origin; optional write at pixel wr_at
   task automatic measure(input int wr_at, input logic [2:0] wsel, input logic [31:0] wdata,
                          output int n, output int n_de, output int n_hs,
                          output int n_vs, output int n_fd);
      n = 0; n_de = 0; n_hs = 0; n_vs = 0; n_fd = 0;
      do step(); while (!(pix_en && pix_x == '0 && line_y == '0));
      while (1) begin
         cfg_we = 1'b0;
         if (pix_en) begin
            n++;
            if (de)    n_de++;
            if (hsync) n_hs++;
            if (vsync) n_vs++;
            if (field) n_fd++;
            if (n == wr_at) begin
               cfg_we = 1'b1; cfg_sel = wsel; cfg_data = wdata;
            end
         end
         step();
         if (pix_en && pix_x == '0 && line_y == '0) break;
      end
      cfg_we = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en_allow = 1'b0;
      repeat (3) step();
      check("R8 pix_x in reset", int'(pix_x), 0);
      check("R8 line_y in reset", int'(line_y), 0);
      check("R8 syncs high in reset", int'({hsync, vsync}), 3);
      check("R8 de/field low in reset", int'({de, field}), 0);
      rst_n = 1'b1;
      step();
      check("R8 pix_x after reset", int'(pix_x), 0);
      en_allow = 1'b1;
   endtask

   task automatic t_gate();
      logic [CNT_W-1:0] x0, y0;
      repeat (7) step();
      en_allow = 1'b0;
      step();
      x0 = pix_x; y0 = line_y;
      repeat (8) step();
      check("R2 pixel held without enable", int'(pix_x), int'(x0));
      check("R2 line held without enable", int'(line_y), int'(y0));
      en_allow = 1'b1;
   endtask

   task automatic t_default();
      int n, a, b, c, d;
      measure(-1, 3'd0, 32'd0, n, a, b, c, d);
      check("R8 default frame pixels", n, 240);
      check("R4 default visible pixels", a, 77);
      check("R3 default hsync pixels", b, 36);
      check("R3 default vsync pixels", c, 40);
   endtask

   task automatic t_progressive();
      int n, a, b, c, d;
      cfg_write(3'd0, 32'h000A_0010);
      cfg_write(3'd1, 32'h0000_0001);
      cfg_write(3'd2, 32'h0002_0004);
      cfg_write(3'd3, 32'h0008_000E);
      cfg_write(3'd4, 32'h0002_0009);
      cfg_write(3'd5, 32'h0000_0000);
      leave_origin();
      measure(-1, 3'd0, 32'd0, n, a, b, c, d);
      check("R1 R2 progressive frame pixels", n, 160);
      check("R4 progressive visible pixels", a, 60);
      check("R3 progressive hsync pixels", b, 20);
      check("R3 progressive vsync pixels", c, 16);
      check("R5 progressive field pixels", d, 0);
   endtask

   task automatic t_shadow();
      int n, a, b, c, d;
      leave_origin();
      measure(50, 3'd0, 32'h000A_0012, n, a, b, c, d);
      check("R7 frame with mid-frame write keeps old length", n, 160);
      measure(-1, 3'd0, 32'd0, n, a, b, c, d);
      check("R7 next frame uses new length", n, 180);
      cfg_write(3'd0, 32'h000A_0010);
      leave_origin();
   endtask

   task automatic t_ignored_sel();
      int n, a, b, c, d;
      cfg_write(3'd6, 32'h0001_0001);
      cfg_write(3'd7, 32'h0003_0003);
      leave_origin();
      measure(-1, 3'd0, 32'd0, n, a, b, c, d);
      check("R9 unused select leaves frame length", n, 160);
      check("R9 unused select leaves visible count", a, 60);
   endtask

   task automatic t_interlace();
      int n, a, b, c, d;
      cfg_write(3'd0, 32'h000D_0010);
      cfg_write(3'd1, 32'h0000_0001);
      cfg_write(3'd2, 32'h0001_0004);
      cfg_write(3'd3, 32'h0004_000E);
      cfg_write(3'd4, 32'h0007_000A);
      cfg_write(3'd5, 32'h0000_0001);
      leave_origin();
      measure(-1, 3'd0, 32'd0, n, a, b, c, d);
      check("R6 interlaced odd frame pixels", n, 208);
      check("R6 interlaced visible pixels", a, 60);
      check("R3 interlaced hsync pixels", b, 26);
      check("R6 interlaced vsync pixels (two fields)", c, 32);
      check("R6 later-field pixels", d, 112);
   endtask

   initial begin
      t_reset();
      t_gate();
      t_default();
      t_progressive();
      t_shadow();
      t_ignored_sel();
      t_interlace();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
   end
endmodule